// File: doc/BRIEF.md
# Clock-Crossing Control Register Writer

This block carries software writes to a small bank of control registers from a fast core clock into a slow clock that is asynchronous to it. The core writes through one port: a select, a data word and a strobe. The slow-domain logic sees a stable copy of every register, plus a command word with a one-cycle strobe. Each register has a busy flag that the core can read. The flag is set while a value is still on its way into the slow domain, so software can tell when a write has landed.

A freeze control holds back every pending transfer. While it is set, several registers can be loaded without any of them reaching the slow side. Clearing it launches all of them in the same core cycle, so they land on the same slow edge. In the default delayed mode, every transfer goes through a two-flop synchronizer and is captured on the third slow edge. In immediate mode, ordinary registers bypass the handshake and show no busy state. The command still reports busy, and it executes on the first slow edge after it is launched. Acknowledgements always come back through a two-flop synchronizer. The mode input is meant to change only while nothing is busy.

Top module: `csync_top`

## Requirements
- R1: After reset, all busy flags, the freeze state, the error flag, every slow-side register, the command word and the command strobe are 0.
- R2: In delayed mode, a write to register k (select k < NREG) sets busy bit k from the core cycle after the write. The bit stays set until the new value is visible on the slow-side output, and it clears within three core cycles after that.
- R3: In delayed mode, a register launched one core cycle after its write is unchanged on the slow side after the first and second slow rising edges that follow the launch, and it carries the new value after the third.
- R4: While the freeze bit is 1 in delayed mode, written registers stay busy and their slow-side values do not change. Clearing the freeze bit moves every held register to the slow side on the same slow edge.
- R5: A write to a register or to the command while its busy bit is set is ignored: the earlier value is the one delivered. The write also sets an error flag that stays set until reset.
- R6: In immediate mode, busy bits 0 to NREG-1 read 0, and the slow-side register output shows a written value from the core cycle after the write.
- R7: In immediate mode, a command write (select NREG) keeps busy bit NREG set until the command executes. It executes on the first slow rising edge after the launch, with a strobe exactly one slow cycle wide, and the command word changes only together with that strobe.
- R8: In delayed mode, a command produces its strobe and value after the third slow rising edge following the launch, and busy bit NREG clears afterwards.
- R9: A write to select NREG+1 loads the freeze bit from data bit 0, and the freeze output reads the stored value back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Fast core clock |
| clk_lf | input | 1 | Slow clock, asynchronous to the core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| imm_mode | input | 1 | 1 selects immediate mode, 0 selects delayed mode |
| wr_en | input | 1 | Core write strobe |
| wr_sel | input | SELW | Target: 0..NREG-1 register, NREG command, NREG+1 freeze |
| wr_data | input | DW | Write data |
| busy | output | NREG+1 | Per-target busy flags; bit NREG is the command |
| frozen | output | 1 | Stored freeze bit |
| wr_err | output | 1 | Sticky flag for a write that was rejected because the target was busy |
| lf_regs | output | NREG*DW | Slow-side register values; register i is at bits i*DW upward |
| lf_cmd | output | DW | Last executed command word |
| lf_cmd_pulse | output | 1 | One slow-cycle strobe when a command executes |

## Verification
Busy goes high in the core cycle after the write strobe. The launch toggle follows one core cycle later. The bench therefore starts each timed write just after a slow edge, so that the launch lands well before the next slow edge. It then counts slow edges from there, sampling 1 ns after each one: first edge and second edge show the old value, the third edge shows the new one (first edge for an immediate command). Busy clearing depends on two core flops after the capturing slow edge. The bench confirms busy is still high right after that edge and low within three core negative edges. Immediate-mode register values are sampled on the first core negative edge after the write.

// File: rtl/csync_pkg.sv
package csync_pkg;
    typedef enum logic {
        XFER_DELAYED   = 1'b0,
        XFER_IMMEDIATE = 1'b1
    } xfer_mode_e;
endpackage

// File: rtl/csync_sync2.sv
module csync_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/csync_core.sv
module csync_core
    import csync_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int SELW = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       imm_mode,
    input  logic                       wr_en,
    input  logic [SELW-1:0]            wr_sel,
    input  logic [DW-1:0]              wr_data,
    input  logic [NREG:0]              ack_tog,
    output logic [NREG:0]              req_tog,
    output logic [NREG:0][DW-1:0]      shadow,
    output logic [NREG:0]              busy,
    output logic                       frozen,
    output logic                       wr_err
);
    localparam int NCH     = NREG + 1;
    localparam int CMD_IDX = NREG;
    localparam int FRZ_SEL = NREG + 1;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] shadow;
        logic [NCH-1:0]         pend;
        logic [NCH-1:0]         req;
        logic                   frz;
        logic                   err;
    } core_t;

    core_t core_d, core_q;
    logic [NCH-1:0] ack_s;
    logic [NCH-1:0] busy_raw;
    logic           imm;

    assign imm = (xfer_mode_e'(imm_mode) == XFER_IMMEDIATE);

    csync_sync2 #(.W(NCH)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ack_tog),
        .dout (ack_s)
    );

    assign busy_raw = core_q.pend | (core_q.req ^ ack_s);

    always_comb begin
        core_d = core_q;
        // launch held requests unless frozen (freeze has no hold in immediate mode)
        for (int i = 0; i < NCH; i++) begin
            if (core_q.pend[i] && (!core_q.frz || imm)) begin
                core_d.req[i]  = ~core_q.req[i];
                core_d.pend[i] = 1'b0;
            end
        end
        if (wr_en) begin
            if (wr_sel == SELW'(FRZ_SEL)) begin
                core_d.frz = wr_data[0];
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (wr_sel == SELW'(i)) begin
                        if (imm && (i != CMD_IDX)) begin
                            core_d.shadow[i] = wr_data;
                        end else if (busy_raw[i]) begin
                            core_d.err = 1'b1;
                        end else begin
                            core_d.shadow[i] = wr_data;
                            core_d.pend[i]   = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            busy[i] = busy_raw[i] & ~(imm & (i != CMD_IDX));
        end
    end

    assign req_tog = core_q.req;
    assign shadow  = core_q.shadow;
    assign frozen  = core_q.frz;
    assign wr_err  = core_q.err;

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.err |=> core_q.err);

    // R4
    frz_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.frz && !imm_mode) |=> $stable(core_q.req));

    for (genvar g = 0; g < NCH; g++) begin : g_hold
        // R5
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_raw[g] && !imm_mode) |=> $stable(core_q.shadow[g]));
    end
endmodule

// File: rtl/csync_lf.sv
module csync_lf
    import csync_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   imm_mode,
    input  logic [NREG:0]          req_tog,
    input  logic [NREG:0][DW-1:0]  shadow,
    output logic [NREG:0]          ack_tog,
    output logic [NREG-1:0][DW-1:0] regs,
    output logic [DW-1:0]          cmd,
    output logic                   cmd_pulse
);
    localparam int NCH     = NREG + 1;
    localparam int CMD_IDX = NREG;

    typedef struct packed {
        logic [NCH-1:0]          seen;
        logic [NREG-1:0][DW-1:0] regs;
        logic [DW-1:0]           cmd;
        logic                    pulse;
    } lf_t;

    lf_t lf_d, lf_q;
    logic [NCH-1:0] req_s;
    logic           imm;
    logic           cmd_src;

    assign imm = (xfer_mode_e'(imm_mode) == XFER_IMMEDIATE);

    csync_sync2 #(.W(NCH)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req_tog),
        .dout (req_s)
    );

    assign cmd_src = imm ? req_tog[CMD_IDX] : req_s[CMD_IDX];

    always_comb begin
        lf_d       = lf_q;
        lf_d.pulse = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (req_s[i] != lf_q.seen[i]) begin
                lf_d.seen[i] = req_s[i];
                lf_d.regs[i] = shadow[i];
            end
        end
        if (cmd_src != lf_q.seen[CMD_IDX]) begin
            lf_d.seen[CMD_IDX] = cmd_src;
            lf_d.cmd           = shadow[CMD_IDX];
            lf_d.pulse         = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lf_q <= '0;
        else        lf_q <= lf_d;
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs[i] = imm ? shadow[i] : lf_q.regs[i];
        end
    end

    assign ack_tog   = lf_q.seen;
    assign cmd       = lf_q.cmd;
    assign cmd_pulse = lf_q.pulse;

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lf_q.pulse |=> !lf_q.pulse);

    // R7
    cmd_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lf_q.pulse || $stable(lf_q.cmd)));

    for (genvar g = 0; g < NREG; g++) begin : g_cap
        // R3
        capture_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (req_s[g] == lf_q.seen[g]) |=> $stable(lf_q.regs[g]));
    end
endmodule

// File: rtl/csync_top.sv
module csync_top #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int SELW = $clog2(NREG + 2)
) (
    input  logic               clk_core,
    input  logic               clk_lf,
    input  logic               rst_n,
    input  logic               imm_mode,
    input  logic               wr_en,
    input  logic [SELW-1:0]    wr_sel,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG:0]      busy,
    output logic               frozen,
    output logic               wr_err,
    output logic [NREG*DW-1:0] lf_regs,
    output logic [DW-1:0]      lf_cmd,
    output logic               lf_cmd_pulse
);
    logic [NREG:0]           req_tog;
    logic [NREG:0]           ack_tog;
    logic [NREG:0][DW-1:0]   shadow;
    logic [NREG-1:0][DW-1:0] regs;

    csync_core #(.NREG(NREG), .DW(DW), .SELW(SELW)) u_core (
        .clk     (clk_core),
        .rst_n   (rst_n),
        .imm_mode(imm_mode),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ack_tog (ack_tog),
        .req_tog (req_tog),
        .shadow  (shadow),
        .busy    (busy),
        .frozen  (frozen),
        .wr_err  (wr_err)
    );

    csync_lf #(.NREG(NREG), .DW(DW)) u_lf (
        .clk      (clk_lf),
        .rst_n    (rst_n),
        .imm_mode (imm_mode),
        .req_tog  (req_tog),
        .shadow   (shadow),
        .ack_tog  (ack_tog),
        .regs     (regs),
        .cmd      (lf_cmd),
        .cmd_pulse(lf_cmd_pulse)
    );

    assign lf_regs = regs;
endmodule

// File: tb/csync_top_test.sv
module csync_top_test;
    localparam int NREG = 4;
    localparam int DW   = 8;
    localparam int SELW = $clog2(NREG + 2);
    localparam int CMD  = NREG;
    localparam int FRZ  = NREG + 1;

    logic clk_core = 1'b0;
    logic clk_lf   = 1'b0;
    logic rst_n    = 1'b0;
    logic imm_mode = 1'b0;
    logic wr_en    = 1'b0;
    logic [SELW-1:0] wr_sel = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [NREG:0]      busy;
    logic               frozen;
    logic               wr_err;
    logic [NREG*DW-1:0] lf_regs;
    logic [DW-1:0]      lf_cmd;
    logic               lf_cmd_pulse;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4  clk_core = ~clk_core;
    always #61 clk_lf   = ~clk_lf;

    csync_top #(.NREG(NREG), .DW(DW)) uut (
        .clk_core(clk_core), .clk_lf(clk_lf), .rst_n(rst_n),
        .imm_mode(imm_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .busy(busy), .frozen(frozen), .wr_err(wr_err), .lf_regs(lf_regs),
        .lf_cmd(lf_cmd), .lf_cmd_pulse(lf_cmd_pulse)
    );

    function automatic logic [DW-1:0] rg(int i);
        return lf_regs[i*DW +: DW];
    endfunction

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wr(int sel, logic [DW-1:0] data);
        @(negedge clk_core);
        wr_en = 1'b1; wr_sel = SELW'(sel); wr_data = data;
        @(negedge clk_core);
        wr_en = 1'b0;
    endtask

    task automatic lf_edge();
        @(posedge clk_lf);
        #1;
    endtask

    task automatic wait_idle(int idx);
        for (int k = 0; k < 400; k++) begin
            if (!busy[idx]) break;
            @(negedge clk_core);
        end
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "frozen", 32'(frozen), 0);
        chk("R1", "err", 32'(wr_err), 0);
        chk("R1", "regs", 32'(lf_regs), 0);
        chk("R1", "cmd", 32'(lf_cmd), 0);
        chk("R1", "pulse", 32'(lf_cmd_pulse), 0);
    endtask

    task automatic t_delayed(int idx, logic [DW-1:0] val);
        logic [DW-1:0] old = rg(idx);
        lf_edge();
        wr(idx, val);
        chk("R2", "busy set", 32'(busy[idx]), 1);
        @(negedge clk_core);
        lf_edge();
        chk("R3", "edge1 old", 32'(rg(idx)), 32'(old));
        lf_edge();
        chk("R3", "edge2 old", 32'(rg(idx)), 32'(old));
        chk("R2", "busy edge2", 32'(busy[idx]), 1);
        lf_edge();
        chk("R3", "edge3 new", 32'(rg(idx)), 32'(val));
        chk("R2", "busy at capture", 32'(busy[idx]), 1);
        repeat (3) @(negedge clk_core);
        chk("R2", "busy cleared", 32'(busy[idx]), 0);
    endtask

    task automatic t_error();
        lf_edge();
        wr(2, 8'h11);
        wr(2, 8'h22);
        chk("R5", "err set", 32'(wr_err), 1);
        wait_idle(2);
        chk("R5", "first value kept", 32'(rg(2)), 32'h11);
        repeat (5) @(negedge clk_core);
        chk("R5", "err sticky", 32'(wr_err), 1);
    endtask

    task automatic t_freeze();
        logic [DW-1:0] o0 = rg(0);
        logic [DW-1:0] o1 = rg(1);
        wr(FRZ, 8'h01);
        chk("R9", "frozen set", 32'(frozen), 1);
        wr(0, 8'h5A);
        wr(1, 8'h6B);
        repeat (5) lf_edge();
        chk("R4", "reg0 held", 32'(rg(0)), 32'(o0));
        chk("R4", "reg1 held", 32'(rg(1)), 32'(o1));
        chk("R4", "busy held", 32'(busy[1:0]), 32'h3);
        lf_edge();
        wr(FRZ, 8'h00);
        chk("R9", "frozen clear", 32'(frozen), 0);
        @(negedge clk_core);
        lf_edge();
        lf_edge();
        chk("R4", "both old", 32'({rg(1), rg(0)}), 32'({o1, o0}));
        lf_edge();
        chk("R4", "both new same edge", 32'({rg(1), rg(0)}), 32'h6B5A);
        wait_idle(0);
        wait_idle(1);
        chk("R4", "busy released", 32'(busy[1:0]), 0);
    endtask

    task automatic t_cmd_delayed();
        lf_edge();
        wr(CMD, 8'h81);
        chk("R8", "cmd busy", 32'(busy[CMD]), 1);
        @(negedge clk_core);
        lf_edge();
        chk("R8", "no pulse edge1", 32'(lf_cmd_pulse), 0);
        lf_edge();
        chk("R8", "no pulse edge2", 32'(lf_cmd_pulse), 0);
        lf_edge();
        chk("R8", "pulse edge3", 32'(lf_cmd_pulse), 1);
        chk("R8", "cmd value", 32'(lf_cmd), 32'h81);
        lf_edge();
        chk("R8", "pulse ends", 32'(lf_cmd_pulse), 0);
        wait_idle(CMD);
        chk("R8", "cmd busy clear", 32'(busy[CMD]), 0);
    endtask

    task automatic t_immediate();
        @(negedge clk_core);
        imm_mode = 1'b1;
        wr(3, 8'hC3);
        chk("R6", "busy reads 0", 32'(busy[NREG-1:0]), 0);
        chk("R6", "reg follows", 32'(rg(3)), 32'hC3);
        lf_edge();
        wr(CMD, 8'h42);
        chk("R7", "cmd busy", 32'(busy[CMD]), 1);
        chk("R7", "no pulse yet", 32'(lf_cmd_pulse), 0);
        @(negedge clk_core);
        lf_edge();
        chk("R7", "pulse edge1", 32'(lf_cmd_pulse), 1);
        chk("R7", "cmd value", 32'(lf_cmd), 32'h42);
        chk("R7", "busy until ack", 32'(busy[CMD]), 1);
        lf_edge();
        chk("R7", "pulse one cycle", 32'(lf_cmd_pulse), 0);
        wait_idle(CMD);
        chk("R7", "cmd busy clear", 32'(busy[CMD]), 0);
        @(negedge clk_core);
        imm_mode = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        #104 rst_n = 1'b1;
        @(negedge clk_core);
        t_reset();
        t_delayed(0, 8'hA5);
        t_delayed(1, 8'hFF);
        t_delayed(3, 8'h3C);
        chk("R3", "other regs intact", 32'(rg(2)), 0);
        t_freeze();
        t_cmd_delayed();
        t_error();
        t_immediate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule